// File: doc/BRIEF.md
# Packet Header Receive Parser

This block sits behind a demodulator and turns its serial output into a decoded packet header. The demodulator presents one bit per symbol strobe. After a restart, the parser looks for a programmable 16-bit start-frame delimiter (SFD) in the bit stream. The search is limited to a window whose length is counted in symbols. If the delimiter does not arrive inside that window, the parser reports a timeout and goes idle.

Once the delimiter is found, the next 48 strobes are captured as four header fields, in this order: an 8-bit signalling byte, an 8-bit service byte, a 16-bit length in bits and a 16-bit CRC. The signalling byte selects the payload modulation. It is compared with two programmable codes, whose usual values are 0x0A for DBPSK at 1 Mbit/s and 0x14 for DQPSK at 2 Mbit/s. A 2-bit mode selects which fields the header CRC covers. A header is announced only when its modulation is recognised and its CRC is good. The captured fields stay readable on the outputs until the next delimiter is detected.

Top module: `hdr_rx_parser`

## Requirements
- R1: After reset, every output is 0 and the parser is idle. Strobes have no effect and raise no timeout until `restart_i` is pulsed.
- R2: Pulsing `restart_i` starts an SFD search. Bits enter least significant bit first, so the first bit received is compared with `sfd_pat_i[0]`. The delimiter is detected on strobe k of the search only if all 16 of its bits arrived after the restart and k is no greater than the window `win_len_i`.
- R3: If no delimiter is found, `timeout_o` is high for exactly one clock after search strobe number `win_len_i` (a window of 0 behaves as 1), and the parser goes idle. In idle, later strobes raise neither a timeout nor a header.
- R4: A delimiter that completes on the last strobe of the window counts as found, and no timeout is raised.
- R5: After the delimiter, field bits are captured least significant bit first, into `sig_o`, `svc_o`, `len_o` and `rx_crc_o` in that order. These outputs change only while a header is being captured. A timeout or a restart leaves them unchanged.
- R6: After the 8th field bit, exactly one of the modulation flags is set. `mod_dbpsk_o` is set when the signalling byte equals `code_bpsk_i`. Otherwise `mod_dqpsk_o` is set when it equals `code_qpsk_i`. Otherwise `mod_unknown_o` is set. All three flags are cleared when a delimiter is detected.
- R7: The CRC is computed MSB-first with the polynomial x^16+x^12+x^5+1 (0x1021), preset to 0xFFFF. Each covered bit is fed in the order it was received; the SFD is fed as `sfd_pat_i[0]` first. The received CRC passes when it equals the ones' complement of the computed value. Coverage by `crc_mode_i`: 0 = no check, 1 = SFD, 2 = SFD then length, 3 = signalling, service and length.
- R8: `hdr_valid_o` is high for exactly one clock after the 48th field strobe, and only if the CRC passes (or the mode is 0) and the modulation is recognised. At that same point, `crc_err_o` is set when the mode is not 0 and the CRC fails; it stays set until the next delimiter is detected.
- R9: `restart_i` aborts any search or header in progress and starts a new search. A strobe in the same cycle as the restart is ignored, and an aborted header never raises `hdr_valid_o`.
- R10: `sym_bit_i` is sampled only in cycles where `sym_stb_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| restart_i | input | 1 | Abort the current header and start a new SFD search |
| sym_stb_i | input | 1 | Symbol strobe, one bit per pulse |
| sym_bit_i | input | 1 | Demodulated bit |
| win_len_i | input | 8 | SFD search window in symbols |
| sfd_pat_i | input | 16 | Delimiter pattern; bit 0 is received first |
| code_bpsk_i | input | 8 | Signalling code for DBPSK |
| code_qpsk_i | input | 8 | Signalling code for DQPSK |
| crc_mode_i | input | 2 | CRC coverage selection |
| sig_o | output | 8 | Captured signalling byte |
| svc_o | output | 8 | Captured service byte |
| len_o | output | 16 | Captured length in bits |
| rx_crc_o | output | 16 | Captured header CRC |
| mod_dbpsk_o | output | 1 | Signalling matched the DBPSK code |
| mod_dqpsk_o | output | 1 | Signalling matched the DQPSK code |
| mod_unknown_o | output | 1 | Signalling matched neither code |
| hdr_valid_o | output | 1 | One-clock pulse for a good header |
| timeout_o | output | 1 | One-clock pulse when the search window expires |
| crc_err_o | output | 1 | The last header failed its CRC |

## Verification
Two events can resolve on the same strobe: the last delimiter bit and the expiry of the search window. The bench provokes this by setting the window to the preamble length plus 16. It then checks that `timeout_o` stays low and that the header which follows completes with `hdr_valid_o`. With the window one symbol shorter, it checks that the timeout is raised on the delimiter's 15th bit and that no header follows. A second collision is a restart raised together with a strobe in the middle of a header. The bench judges that case by the exact strobe on which the new search times out, and by the absence of any `hdr_valid_o`.

// File: rtl/hdr_rx_pkg.sv
package hdr_rx_pkg;
  localparam int SFD_W    = 16;
  localparam int SIG_W    = 8;
  localparam int SVC_W    = 8;
  localparam int LEN_W    = 16;
  localparam int CRC_W    = 16;
  localparam int OFS_SVC  = SIG_W;
  localparam int OFS_LEN  = OFS_SVC + SVC_W;
  localparam int OFS_CRC  = OFS_LEN + LEN_W;
  localparam int HDR_BITS = OFS_CRC + CRC_W;
  localparam int IDX_W    = $clog2(HDR_BITS);

  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;

  typedef enum logic [1:0] {ST_IDLE, ST_SEARCH, ST_FIELDS} rx_state_e;
  typedef enum logic [1:0] {CRC_OFF, CRC_SFD, CRC_SFD_LEN, CRC_SIG_LEN} crc_mode_e;

  function automatic logic [CRC_W-1:0] crc_step(logic [CRC_W-1:0] c, logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  function automatic logic [CRC_W-1:0] crc_of_pattern(logic [SFD_W-1:0] pat);
    logic [CRC_W-1:0] c;
    c = CRC_SEED;
    for (int i = 0; i < SFD_W; i++) c = crc_step(c, pat[i]);
    return c;
  endfunction
endpackage

// File: rtl/hdr_sfd_search.sv
module hdr_sfd_search #(
  parameter int PAT_W = 16,
  parameter int WIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             bit_i,
  input  logic [PAT_W-1:0] pat_i,
  input  logic [WIN_W-1:0] win_i,
  output logic             hit_o,
  output logic             expire_o
);
  localparam int FILL_W = $clog2(PAT_W + 1);
  localparam int CNT_W  = WIN_W + 1;

  logic [PAT_W-1:0]  shift_q, shift_d;
  logic [FILL_W-1:0] fill_q;
  logic [CNT_W-1:0]  win_q;
  logic              full;

  assign shift_d  = {bit_i, shift_q[PAT_W-1:1]};
  assign full     = fill_q >= FILL_W'(PAT_W - 1);
  assign hit_o    = en_i && full && (shift_d == pat_i);
  // window test uses the strobe being taken now
  assign expire_o = en_i && !hit_o && ((win_q + 1'b1) >= {1'b0, win_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      fill_q  <= '0;
      win_q   <= '0;
    end else if (clr_i) begin
      shift_q <= '0;
      fill_q  <= '0;
      win_q   <= '0;
    end else if (en_i) begin
      shift_q <= shift_d;
      if (fill_q != FILL_W'(PAT_W)) fill_q <= fill_q + 1'b1;
      win_q <= win_q + 1'b1;
    end
  end

  AST_WIN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> ((win_q < {1'b0, win_i}) || (win_q == '0))); // R3
endmodule

// File: rtl/hdr_crc16.sv
module hdr_crc16
  import hdr_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic [CRC_W-1:0] init_val_i,
  input  logic             step_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_SEED;
    else if (init_i) crc_q <= init_val_i;
    else if (step_i) crc_q <= crc_step(crc_q, bit_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/hdr_field_cap.sv
module hdr_field_cap #(
  parameter int N = 48
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 stb_i,
  input  logic                 bit_i,
  output logic [$clog2(N)-1:0] idx_o,
  output logic [N-1:0]         hdr_o
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] idx_q;
  logic [N-1:0]  hdr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (start_i) idx_q <= '0;
    else if (stb_i)   idx_q <= idx_q + 1'b1;
  end

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           hdr_q[g] <= 1'b0;
      else if (stb_i && idx_q == IW'(g))     hdr_q[g] <= bit_i;
    end
  end

  assign idx_o = idx_q;
  assign hdr_o = hdr_q;

  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |-> (idx_q < IW'(N))); // R5
endmodule

// File: rtl/hdr_rx_parser.sv
module hdr_rx_parser
  import hdr_rx_pkg::*;
#(
  parameter int WIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             sym_stb_i,
  input  logic             sym_bit_i,
  input  logic [WIN_W-1:0] win_len_i,
  input  logic [SFD_W-1:0] sfd_pat_i,
  input  logic [SIG_W-1:0] code_bpsk_i,
  input  logic [SIG_W-1:0] code_qpsk_i,
  input  logic [1:0]       crc_mode_i,
  output logic [SIG_W-1:0] sig_o,
  output logic [SVC_W-1:0] svc_o,
  output logic [LEN_W-1:0] len_o,
  output logic [CRC_W-1:0] rx_crc_o,
  output logic             mod_dbpsk_o,
  output logic             mod_dqpsk_o,
  output logic             mod_unknown_o,
  output logic             hdr_valid_o,
  output logic             timeout_o,
  output logic             crc_err_o
);
  rx_state_e state_q;
  crc_mode_e mode;

  logic                search_en, sfd_hit, sfd_expire;
  logic                fld_stb, sig_done, hdr_last, covered;
  logic [IDX_W-1:0]    idx;
  logic [HDR_BITS-1:0] hdr;
  logic [SIG_W-1:0]    sig_full;
  logic [CRC_W-1:0]    rx_crc_full, crc_val, crc_init;
  logic                crc_ok;
  logic                bpsk_q, qpsk_q, unk_q, valid_q, tmo_q, crc_err_q;

  assign mode      = crc_mode_e'(crc_mode_i);
  assign search_en = sym_stb_i && !restart_i && (state_q == ST_SEARCH);
  assign fld_stb   = sym_stb_i && !restart_i && (state_q == ST_FIELDS);

  hdr_sfd_search #(.PAT_W(SFD_W), .WIN_W(WIN_W)) u_search (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (restart_i),
    .en_i     (search_en),
    .bit_i    (sym_bit_i),
    .pat_i    (sfd_pat_i),
    .win_i    (win_len_i),
    .hit_o    (sfd_hit),
    .expire_o (sfd_expire)
  );

  hdr_field_cap #(.N(HDR_BITS)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sfd_hit),
    .stb_i   (fld_stb),
    .bit_i   (sym_bit_i),
    .idx_o   (idx),
    .hdr_o   (hdr)
  );

  // coverage per mode over field bit index
  always_comb begin
    unique case (mode)
      CRC_SFD_LEN: covered = (idx >= IDX_W'(OFS_LEN)) && (idx < IDX_W'(OFS_CRC));
      CRC_SIG_LEN: covered = idx < IDX_W'(OFS_CRC);
      default:     covered = 1'b0;
    endcase
  end

  assign crc_init = ((mode == CRC_SFD) || (mode == CRC_SFD_LEN)) ? crc_of_pattern(sfd_pat_i)
                                                                  : CRC_SEED;

  hdr_crc16 u_crc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (sfd_hit),
    .init_val_i (crc_init),
    .step_i     (fld_stb && covered),
    .bit_i      (sym_bit_i),
    .crc_o      (crc_val)
  );

  assign sig_done    = fld_stb && (idx == IDX_W'(SIG_W - 1));
  assign hdr_last    = fld_stb && (idx == IDX_W'(HDR_BITS - 1));
  assign sig_full    = {sym_bit_i, hdr[SIG_W-2:0]};
  assign rx_crc_full = {sym_bit_i, hdr[HDR_BITS-2:OFS_CRC]};
  assign crc_ok      = (mode == CRC_OFF) || (rx_crc_full == ~crc_val);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bpsk_q    <= 1'b0;
      qpsk_q    <= 1'b0;
      unk_q     <= 1'b0;
      valid_q   <= 1'b0;
      tmo_q     <= 1'b0;
      crc_err_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      tmo_q   <= 1'b0;
      if (restart_i) begin
        state_q <= ST_SEARCH;
      end else begin
        unique case (state_q)
          ST_SEARCH: begin
            if (sfd_hit) begin
              state_q   <= ST_FIELDS;
              bpsk_q    <= 1'b0;
              qpsk_q    <= 1'b0;
              unk_q     <= 1'b0;
              crc_err_q <= 1'b0;
            end else if (sfd_expire) begin
              tmo_q   <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
          ST_FIELDS: begin
            if (sig_done) begin
              bpsk_q <= (sig_full == code_bpsk_i);
              qpsk_q <= (sig_full != code_bpsk_i) && (sig_full == code_qpsk_i);
              unk_q  <= (sig_full != code_bpsk_i) && (sig_full != code_qpsk_i);
            end
            if (hdr_last) begin
              state_q   <= ST_IDLE;
              crc_err_q <= !crc_ok;
              valid_q   <= crc_ok && (bpsk_q || qpsk_q);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sig_o         = hdr[SIG_W-1:0];
  assign svc_o         = hdr[OFS_LEN-1:OFS_SVC];
  assign len_o         = hdr[OFS_CRC-1:OFS_LEN];
  assign rx_crc_o      = hdr[HDR_BITS-1:OFS_CRC];
  assign mod_dbpsk_o   = bpsk_q;
  assign mod_dqpsk_o   = qpsk_q;
  assign mod_unknown_o = unk_q;
  assign hdr_valid_o   = valid_q;
  assign timeout_o     = tmo_q;
  assign crc_err_o     = crc_err_q;

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |=> !hdr_valid_o); // R8
  AST_VALID_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> (!crc_err_o && !mod_unknown_o && state_q == ST_IDLE)); // R8
  AST_TIMEOUT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o); // R3
  AST_TIMEOUT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (state_q == ST_IDLE)); // R3
  AST_MOD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mod_dbpsk_o, mod_dqpsk_o, mod_unknown_o})); // R6
  AST_RESTART_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!hdr_valid_o && !timeout_o && state_q == ST_SEARCH)); // R9
  AST_FIELDS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_FIELDS) |=> $stable(sig_o) && $stable(len_o)); // R5
endmodule

// File: tb/hdr_rx_parser_tb.sv
module hdr_rx_parser_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        restart = 1'b0;
  logic        stb = 1'b0;
  logic        sbit = 1'b0;
  logic [7:0]  win = 8'd40;
  logic [15:0] sfd = 16'hF3A0;
  logic [7:0]  cb = 8'h0A;
  logic [7:0]  cq = 8'h14;
  logic [1:0]  mode = 2'd0;
  logic [7:0]  sig_o, svc_o;
  logic [15:0] len_o, crc_o;
  logic        dbpsk_o, dqpsk_o, unk_o, valid_o, tmo_o, err_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] last_sig = 8'h00;

  always #2 clk = ~clk;

  hdr_rx_parser u_dut (
    .clk_i(clk), .rst_ni(rst_n), .restart_i(restart), .sym_stb_i(stb), .sym_bit_i(sbit),
    .win_len_i(win), .sfd_pat_i(sfd), .code_bpsk_i(cb), .code_qpsk_i(cq), .crc_mode_i(mode),
    .sig_o(sig_o), .svc_o(svc_o), .len_o(len_o), .rx_crc_o(crc_o),
    .mod_dbpsk_o(dbpsk_o), .mod_dqpsk_o(dqpsk_o), .mod_unknown_o(unk_o),
    .hdr_valid_o(valid_o), .timeout_o(tmo_o), .crc_err_o(err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one idle cycle with a garbage bit, then one strobe; returns just after the strobe edge
  task automatic send_bit(input logic b);
    stb = 1'b0; sbit = ~b;
    @(negedge clk);
    stb = 1'b1; sbit = b;
    @(negedge clk);
    stb = 1'b0; sbit = ~b;
  endtask

  task automatic pulse_restart();
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  function automatic logic [15:0] b_crc(input logic [15:0] seed, input logic [47:0] d, input int n);
    logic [15:0] c = seed;
    for (int i = 0; i < n; i++) begin
      if (c[15] ^ d[i]) c = (c << 1) ^ 16'h1021;
      else              c = c << 1;
    end
    return c;
  endfunction

  function automatic logic [15:0] exp_crc(input logic [1:0] m, input logic [7:0] s,
                                          input logic [7:0] v, input logic [15:0] l);
    logic [15:0] sc = b_crc(16'hFFFF, {32'h0, sfd}, 16);
    case (m)
      2'd1:    return sc;
      2'd2:    return b_crc(sc, {32'h0, l}, 16);
      2'd3:    return b_crc(16'hFFFF, {16'h0, l, v, s}, 32);
      default: return 16'h0;
    endcase
  endfunction

  // exp_mod: {dbpsk, dqpsk, unknown}
  task automatic run_header(input int pre, input logic [7:0] s, input logic [7:0] v,
                            input logic [15:0] l, input logic [15:0] cf,
                            input logic [2:0] exp_mod, input logic exp_valid, input logic exp_err);
    logic [47:0] h = {cf, l, v, s};
    pulse_restart();
    for (int i = 0; i < pre; i++) send_bit(1'b0);
    for (int i = 0; i < 16; i++) send_bit(sfd[i]);
    chk("R4", {31'h0, tmo_o}, 32'h0, "no timeout on delimiter");
    for (int i = 0; i < 48; i++) begin
      send_bit(h[i]);
      if (i == 7) chk("R6", {29'h0, dbpsk_o, dqpsk_o, unk_o}, {29'h0, exp_mod}, "modulation flags");
    end
    chk("R8", {31'h0, valid_o}, {31'h0, exp_valid}, "header valid");
    chk("R7", {31'h0, err_o}, {31'h0, exp_err}, "crc error");
    chk("R5", {24'h0, sig_o}, {24'h0, s}, "signalling");
    chk("R5", {24'h0, svc_o}, {24'h0, v}, "service");
    chk("R10", {16'h0, len_o}, {16'h0, l}, "length with gap noise");
    chk("R5", {16'h0, crc_o}, {16'h0, cf}, "received crc");
    @(negedge clk);
    chk("R8", {31'h0, valid_o}, 32'h0, "valid is one clock");
    last_sig = s;
  endtask

  task automatic run_timeout(input int w);
    int lim = (w == 0) ? 1 : w;
    win = 8'(w);
    pulse_restart();
    for (int k = 1; k <= lim; k++) begin
      send_bit(1'b0);
      if (k == lim)          chk("R3", {31'h0, tmo_o}, 32'h1, "timeout at window end");
      else if (k == lim - 1) chk("R3", {31'h0, tmo_o}, 32'h0, "no timeout before window end");
    end
    @(negedge clk);
    chk("R3", {31'h0, tmo_o}, 32'h0, "timeout is one clock");
    for (int i = 0; i < 16; i++) send_bit(sfd[i]);
    for (int i = 0; i < 8; i++) send_bit(~last_sig[i]);
    chk("R3", {30'h0, tmo_o, valid_o}, 32'h0, "idle ignores strobes");
    chk("R5", {24'h0, sig_o}, {24'h0, last_sig}, "fields held after timeout");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL all: watchdog expired, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]  sigs [3] = '{8'h0A, 8'h14, 8'h5C};
    logic [15:0] good, cf, alt, l;
    logic [2:0]  em;
    logic        known, ev, ee;

    @(negedge clk);
    chk("R1", {sig_o, svc_o, len_o}, 32'h0, "fields in reset");
    chk("R1", {16'h0, crc_o}, 32'h0, "crc field in reset");
    chk("R1", {26'h0, dbpsk_o, dqpsk_o, unk_o, valid_o, tmo_o, err_o}, 32'h0, "flags in reset");
    rst_n = 1'b1;
    win = 8'd0;
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    chk("R1", {31'h0, tmo_o}, 32'h0, "idle after reset");
    win = 8'd40;

    // sweep of mode x signalling x crc integrity
    for (int m = 0; m < 4; m++) begin
      for (int si = 0; si < 3; si++) begin
        for (int g = 0; g < 2; g++) begin
          mode = 2'(m);
          l = 16'(m * 256 + si * 37 + 1);
          good = ~exp_crc(2'(m), sigs[si], 8'(si * 3), l);
          cf = (g == 1) ? good : (good ^ 16'h0100);
          known = (si != 2);
          em = (si == 0) ? 3'b100 : (si == 1) ? 3'b010 : 3'b001;
          ev = known && (m == 0 || g == 1);
          ee = (m != 0) && (g == 0);
          run_header(8, sigs[si], 8'(si * 3), l, cf, em, ev, ee);
        end
      end
      if (m != 0) begin
        // CRC built for the wrong coverage
        l = 16'h2C5;
        good = ~exp_crc(2'(m), 8'h14, 8'h00, l);
        alt  = ~exp_crc(2'((m % 3) + 1), 8'h14, 8'h00, l);
        run_header(8, 8'h14, 8'h00, l, alt, 3'b010, alt == good, alt != good);
      end
    end

    // R2: delimiter must complete after the restart and inside the window
    mode = 2'd0;
    run_header(0, 8'h0A, 8'h00, 16'h0040, 16'h0, 3'b100, 1'b1, 1'b0);

    // R6: equal codes give DBPSK precedence; reprogrammed code
    cq = 8'h0A;
    run_header(8, 8'h0A, 8'h00, 16'h0010, 16'h0, 3'b100, 1'b1, 1'b0);
    cq = 8'h14; cb = 8'h33;
    run_header(8, 8'h33, 8'h00, 16'h0011, 16'h0, 3'b100, 1'b1, 1'b0);
    run_header(8, 8'h0A, 8'h00, 16'h0012, 16'h0, 3'b001, 1'b0, 1'b0);
    cb = 8'h0A;

    // R3 window sweep
    run_timeout(0);
    run_timeout(1);
    run_timeout(5);
    run_timeout(17);

    // R4: delimiter on the last window strobe beats the timeout
    win = 8'd19;
    run_header(3, 8'h14, 8'h00, 16'h0100, 16'h0, 3'b010, 1'b1, 1'b0);
    win = 8'd18;
    pulse_restart();
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    for (int i = 0; i < 15; i++) send_bit(sfd[i]);
    chk("R4", {31'h0, tmo_o}, 32'h1, "window one short times out");
    send_bit(sfd[15]);
    for (int i = 0; i < 48; i++) send_bit(1'b0);
    chk("R4", {31'h0, valid_o}, 32'h0, "no header after timeout");

    // R9: restart with a strobe mid-header
    win = 8'd40;
    pulse_restart();
    for (int i = 0; i < 8; i++) send_bit(1'b0);
    for (int i = 0; i < 16; i++) send_bit(sfd[i]);
    for (int i = 0; i < 20; i++) send_bit(1'b1);
    stb = 1'b1; sbit = 1'b0; restart = 1'b1;
    @(negedge clk);
    stb = 1'b0; restart = 1'b0;
    begin
      int seen_valid = 0;
      for (int k = 1; k <= 40; k++) begin
        send_bit(1'b0);
        if (valid_o) seen_valid++;
        if (k == 39) chk("R9", {31'h0, tmo_o}, 32'h0, "restart strobe not counted");
        if (k == 40) chk("R9", {31'h0, tmo_o}, 32'h1, "new window after restart");
      end
      chk("R9", 32'(seen_valid), 32'h0, "aborted header gives no valid");
    end
    chk("R5", {24'h0, sig_o}, 32'hFF, "fields held after restart");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule